// File: doc/BRIEF.md
# Configuration Chain Overflow Forwarder

This block sits beside the configuration loader of a device that can be daisy-chained with further devices. While the local device is still taking its own configuration data, the block keeps its chain outputs quiet: the serial data-out line is held high and the downstream chip-select is held inactive. When the loader reports that the local device has everything it needs, the block switches to the chain option chosen for this device. It then forwards the remaining part of the stream to the next device until the wake-up sequence ends.

Two forwarding options exist. With bypass, the data goes out on `dout` through a single bypass flop. In serial mode each incoming bit is copied across. In parallel mode each received byte is turned into eight serial bits, most significant bit first, and a busy flag holds off new bytes while that happens. With flow-through, which only makes sense on a byte-wide port, the block pulls the downstream chip-select low and asks for the local byte data, init and busy drivers to be tri-stated. The chosen option is latched on entry and stays active until wake-up completes. After that the outputs return to their idle levels until the next reset. When the device configures itself from its own internal storage, no forwarding of any kind is allowed.

Top module: `cfg_chain_overflow`

## Requirements
- R1: After reset, `dout` is 1, `cs_out_n` is 1, `local_hiz` is 0 and `shift_busy` is 0.
- R2: Before an accepted `local_done`, `dout` stays 1 and `shift_busy` stays 0, whatever `ser_in`, `byte_in` and `byte_vld` do.
- R3: In serial bypass (`par_mode`=0, `chain_opt`=2'b01 when `local_done` is taken), `dout` after each clock edge equals `ser_in` as sampled at that edge. The first bit is captured at the edge that follows `local_done`.
- R4: In parallel bypass (`par_mode`=1, `chain_opt`=2'b01), a byte taken at edge E appears on `dout` one bit per clock after edges E+1 through E+8. The order is `byte_in[7]` (the most significant bit) first, then `byte_in[6]`, down to `byte_in[0]` last.
- R5: `shift_busy` is 1 from the accepting edge until the eighth bit has been shifted. A `byte_vld` pulse while it is 1 is ignored and does not change the bits already in flight.
- R6: In flow-through (`par_mode`=1, `chain_opt`=2'b10), after the edge that takes `local_done`, `cs_out_n` is 0 and `local_hiz` is 1, while `dout` stays 1.
- R7: Flow-through with `par_mode`=0 has no effect: `cs_out_n` stays 1, `local_hiz` stays 0 and `dout` stays 1.
- R8: While `self_dl` is 1, `local_done` is ignored and the block stays idle.
- R9: Once forwarding has started, later changes of `chain_opt` or `par_mode` have no effect until `wake_done`.
- R10: A `wake_done` during forwarding returns `dout` to 1, `cs_out_n` to 1, `local_hiz` to 0 and `shift_busy` to 0 after that edge. Any later `local_done` is ignored until reset.
- R11: With `chain_opt` 2'b00 (disabled) or 2'b11 (reserved), `local_done` starts no forwarding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low reset, start of a configuration |
| par_mode | input | 1 | 1 = byte-wide port, 0 = serial port |
| chain_opt | input | 2 | 00 off, 01 bypass, 10 flow-through, 11 reserved |
| self_dl | input | 1 | Device is loading from its own internal storage |
| ser_in | input | 1 | Serial configuration data |
| byte_in | input | 8 | Byte-wide configuration data, bit 7 most significant |
| byte_vld | input | 1 | Strobe marking a valid byte on `byte_in` |
| local_done | input | 1 | One-cycle pulse: local device holds all its data |
| wake_done | input | 1 | Wake-up sequence has finished |
| dout | output | 1 | Chain data out, through the bypass flop |
| cs_out_n | output | 1 | Active-low chip-select to the next device |
| local_hiz | output | 1 | Request to tri-state local byte data, init and busy drivers |
| shift_busy | output | 1 | Byte serializer is occupied |

## Verification
The bench targets the bit order of the byte serializer. A design that shifted out the least significant bit first, or lost the last bit, would put a mirrored or truncated pattern on `dout`. It also sends a byte strobe into a busy serializer; a design that reloaded there would corrupt the bits in flight. Option latching is tested by changing `chain_opt` and `par_mode` during forwarding, which a non-latching design would follow. The bench also checks the ignore paths (flow-through on a serial port, self-download, off and reserved options, and `local_done` after wake-up), each of which a careless design would let start forwarding.

// File: rtl/cco_pkg.sv
package cco_pkg;

  typedef enum logic [1:0] {
    CH_OFF    = 2'b00,
    CH_BYPASS = 2'b01,
    CH_FLOW   = 2'b10,
    CH_RSVD   = 2'b11
  } chain_opt_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_BYPASS = 2'b01,
    ST_FLOW   = 2'b10,
    ST_DONE   = 2'b11
  } ovf_state_e;

  // Forwarding state selected when the local device reports completion.
  function automatic ovf_state_e pick_mode(input logic [1:0] opt, input logic par);
    ovf_state_e res;
    case (opt)
      CH_BYPASS: res = ST_BYPASS;
      CH_FLOW:   res = par ? ST_FLOW : ST_IDLE;
      default:   res = ST_IDLE;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/cco_mode_ctrl.sv
module cco_mode_ctrl
  import cco_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       par_mode,
  input  logic [1:0] chain_opt,
  input  logic       self_dl,
  input  logic       local_done,
  input  logic       wake_done,
  output ovf_state_e state,
  output logic       lat_par
);

  ovf_state_e state_q;
  logic       par_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      par_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (local_done && !self_dl) begin
            state_q <= pick_mode(chain_opt, par_mode);
            par_q   <= par_mode;
          end
        end
        ST_BYPASS, ST_FLOW: begin
          if (wake_done) state_q <= ST_DONE;
        end
        default: state_q <= ST_DONE;
      endcase
    end
  end

  assign state   = state_q;
  assign lat_par = par_q;

endmodule

// File: rtl/cco_bypass_shift.sv
module cco_bypass_shift #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en,
  input  logic              par_en,
  input  logic              clear,
  input  logic              ser_in,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_vld,
  output logic              bit_q,
  output logic              busy,
  output logic              load
);

  localparam int CNT_W = $clog2(BYTE_W + 1);

  logic [BYTE_W-1:0] shreg;
  logic [CNT_W-1:0]  cnt;
  logic              bq;

  assign busy = (cnt != '0);
  assign load = par_en && byte_vld && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bq    <= 1'b1;
      shreg <= '0;
      cnt   <= '0;
    end else if (clear) begin
      bq    <= 1'b1;
      cnt   <= '0;
    end else begin
      if (ser_en) bq <= ser_in;
      if (par_en) begin
        if (load) begin
          shreg <= byte_in;
          cnt   <= CNT_W'(BYTE_W);
        end else if (busy) begin
          bq    <= shreg[BYTE_W-1];
          shreg <= shreg << 1;
          cnt   <= cnt - 1'b1;
        end
      end
    end
  end

  assign bit_q = bq;

endmodule

// File: rtl/cfg_chain_overflow.sv
module cfg_chain_overflow
  import cco_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              par_mode,
  input  logic [1:0]        chain_opt,
  input  logic              self_dl,
  input  logic              ser_in,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              byte_vld,
  input  logic              local_done,
  input  logic              wake_done,
  output logic              dout,
  output logic              cs_out_n,
  output logic              local_hiz,
  output logic              shift_busy
);

  ovf_state_e state;
  logic       lat_par;
  logic       in_idle, in_bypass, in_flow, finished;
  logic       ser_en, par_en, leave_fwd, byte_load;

  cco_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .par_mode   (par_mode),
    .chain_opt  (chain_opt),
    .self_dl    (self_dl),
    .local_done (local_done),
    .wake_done  (wake_done),
    .state      (state),
    .lat_par    (lat_par)
  );

  assign in_idle   = (state == ST_IDLE);
  assign in_bypass = (state == ST_BYPASS);
  assign in_flow   = (state == ST_FLOW);
  assign finished  = (state == ST_DONE);
  assign ser_en    = in_bypass && !lat_par;
  assign par_en    = in_bypass && lat_par;
  assign leave_fwd = wake_done && (in_bypass || in_flow);

  cco_bypass_shift #(.BYTE_W(BYTE_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ser_en   (ser_en),
    .par_en   (par_en),
    .clear    (leave_fwd),
    .ser_in   (ser_in),
    .byte_in  (byte_in),
    .byte_vld (byte_vld),
    .bit_q    (dout),
    .busy     (shift_busy),
    .load     (byte_load)
  );

  assign cs_out_n  = !in_flow;
  assign local_hiz = in_flow;

endmodule

// File: rtl/cco_chain_checker.sv
module cco_chain_checker (
  input logic clk,
  input logic rst_n,
  input logic par_mode,
  input logic self_dl,
  input logic ser_in,
  input logic byte_vld,
  input logic local_done,
  input logic wake_done,
  input logic dout,
  input logic local_hiz,
  input logic shift_busy,
  input logic in_idle,
  input logic in_bypass,
  input logic in_flow,
  input logic finished,
  input logic lat_par
);

  AST_QUIET_DOUT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_bypass |-> dout); // R2

  AST_SERIAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bypass && !lat_par && !wake_done) |=> (dout == $past(ser_in))); // R3

  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shift_busy) |-> ($past(byte_vld) && $past(in_bypass))); // R5

  AST_BUSY_PAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    shift_busy |-> (in_bypass && lat_par)); // R5

  AST_FLOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_flow) |-> ($past(local_done) && $past(par_mode) && !$past(self_dl))); // R6

  AST_FLOW_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    in_flow |-> (local_hiz && dout)); // R6

  AST_SELF_DL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && self_dl) |=> in_idle); // R8

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bypass && !wake_done) |=> in_bypass); // R9

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    finished |=> (finished && dout && !local_hiz)); // R10

endmodule

bind cfg_chain_overflow cco_chain_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .par_mode   (par_mode),
  .self_dl    (self_dl),
  .ser_in     (ser_in),
  .byte_vld   (byte_vld),
  .local_done (local_done),
  .wake_done  (wake_done),
  .dout       (dout),
  .local_hiz  (local_hiz),
  .shift_busy (shift_busy),
  .in_idle    (in_idle),
  .in_bypass  (in_bypass),
  .in_flow    (in_flow),
  .finished   (finished),
  .lat_par    (lat_par)
);

// File: tb/test_cfg_chain_overflow.sv
`timescale 1ns/1ps
module test_cfg_chain_overflow;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       par_mode;
  logic [1:0] chain_opt;
  logic       self_dl;
  logic       ser_in;
  logic [7:0] byte_in;
  logic       byte_vld;
  logic       local_done;
  logic       wake_done;
  logic       dout, cs_out_n, local_hiz, shift_busy;

  int checks   = 0;
  int failures = 0;

  always #5 clk = ~clk;

  cfg_chain_overflow i_cfg_chain_overflow (
    .clk(clk), .rst_n(rst_n), .par_mode(par_mode), .chain_opt(chain_opt),
    .self_dl(self_dl), .ser_in(ser_in), .byte_in(byte_in), .byte_vld(byte_vld),
    .local_done(local_done), .wake_done(wake_done), .dout(dout),
    .cs_out_n(cs_out_n), .local_hiz(local_hiz), .shift_busy(shift_busy)
  );

  // {ser_in driven, dout expected after that edge}
  localparam logic [1:0] SER_VEC [0:11] = '{
    2'b00, 2'b11, 2'b11, 2'b00, 2'b11, 2'b00,
    2'b00, 2'b00, 2'b11, 2'b11, 2'b00, 2'b11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; par_mode = 1'b0; chain_opt = 2'b00; self_dl = 1'b0;
    ser_in = 1'b1; byte_in = 8'h00; byte_vld = 1'b0; local_done = 1'b0; wake_done = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic enter(input logic par, input logic [1:0] opt);
    par_mode = par; chain_opt = opt; local_done = 1'b1;
    tick();
    local_done = 1'b0;
  endtask

  task automatic wake();
    wake_done = 1'b1;
    tick();
    wake_done = 1'b0;
  endtask

  // Expected serial order: most significant bit first.
  function automatic logic nth_out(input logic [7:0] b, input int k);
    return b[7-k];
  endfunction

  task automatic send_byte(input logic [7:0] b, input logic poke);
    byte_in = b; byte_vld = 1'b1;
    tick();
    byte_vld = 1'b0;
    check("R5 busy after accept", shift_busy, 1);
    for (int k = 0; k < 8; k++) begin
      if (poke && k == 2) begin byte_in = 8'hFF; byte_vld = 1'b1; end
      tick();
      byte_vld = 1'b0;
      check("R4 byte bit order", dout, nth_out(b, k));
    end
    check("R5 busy clears after 8 bits", shift_busy, 0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    do_reset();
    // R1
    check("R1 dout reset", dout, 1);
    check("R1 cs_out_n reset", cs_out_n, 1);
    check("R1 local_hiz reset", local_hiz, 0);
    check("R1 busy reset", shift_busy, 0);

    // R2: no forwarding before completion
    par_mode = 1'b1; chain_opt = 2'b01; ser_in = 1'b0; byte_in = 8'h00; byte_vld = 1'b1;
    tick(); tick();
    byte_vld = 1'b0;
    check("R2 dout quiet", dout, 1);
    check("R2 busy quiet", shift_busy, 0);

    // R3: serial bypass vector walk
    do_reset();
    enter(1'b0, 2'b01);
    check("R3 dout before first bit", dout, 1);
    for (int i = 0; i < 12; i++) begin
      ser_in = SER_VEC[i][1];
      tick();
      check("R3 serial pass", dout, SER_VEC[i][0]);
    end
    // R9: option change ignored while forwarding
    chain_opt = 2'b10; par_mode = 1'b1; ser_in = 1'b0;
    tick();
    check("R9 still serial bypass dout", dout, 0);
    check("R9 cs_out_n unchanged", cs_out_n, 1);
    ser_in = 1'b1;
    tick();
    check("R9 still following ser_in", dout, 1);
    ser_in = 1'b0;
    // R10: wake-up ends forwarding for good
    wake();
    check("R10 dout high after wake", dout, 1);
    enter(1'b0, 2'b01);
    tick();
    check("R10 local_done ignored after wake", dout, 1);

    // R4 / R5: parallel bypass
    do_reset();
    enter(1'b1, 2'b01);
    send_byte(8'hB4, 1'b0);
    send_byte(8'h5A, 1'b1);
    send_byte(8'h01, 1'b0);
    wake();
    check("R10 dout high after parallel wake", dout, 1);
    check("R10 busy low after wake", shift_busy, 0);

    // R6: flow-through
    do_reset();
    enter(1'b1, 2'b10);
    check("R6 cs_out_n low", cs_out_n, 0);
    check("R6 local_hiz high", local_hiz, 1);
    ser_in = 1'b0;
    tick();
    check("R6 dout stays high", dout, 1);
    wake();
    check("R10 cs_out_n released", cs_out_n, 1);
    check("R10 local_hiz released", local_hiz, 0);
    enter(1'b1, 2'b10);
    check("R10 flow not re-entered", cs_out_n, 1);

    // R7: flow-through on serial port
    do_reset();
    enter(1'b0, 2'b10);
    ser_in = 1'b0;
    tick();
    check("R7 cs_out_n stays high", cs_out_n, 1);
    check("R7 local_hiz stays low", local_hiz, 0);
    check("R7 dout stays high", dout, 1);

    // R8: self-download
    do_reset();
    self_dl = 1'b1;
    enter(1'b0, 2'b01);
    ser_in = 1'b0;
    tick();
    check("R8 serial bypass blocked", dout, 1);
    enter(1'b1, 2'b10);
    check("R8 flow blocked", cs_out_n, 1);
    self_dl = 1'b0;

    // R11: off and reserved options
    do_reset();
    enter(1'b0, 2'b00);
    ser_in = 1'b0;
    tick();
    check("R11 off option", dout, 1);
    enter(1'b1, 2'b11);
    byte_in = 8'h00; byte_vld = 1'b1;
    tick();
    byte_vld = 1'b0;
    check("R11 reserved option busy", shift_busy, 0);
    check("R11 reserved option cs", cs_out_n, 1);
    tick();
    check("R11 reserved option dout", dout, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule